// File: doc/BRIEF.md
# Adaptive Equalizer Inner-Tap Coefficient Controller

This block is the digital adaptation loop behind the two inner taps of a five-tap transversal equalizer in a disk read channel. Each valid cycle it takes one signed equalizer output sample, the ternary symbol detected at that sample, and the symbol detected next to it. From these it forms a zero-forcing error and integrates it into a signed coefficient. The coefficient drives both inner taps at once, so the block has two identical coefficient outputs.

Adaptation follows the read sequence. When a read starts, a training window runs at full loop gain. In that window the media carries repeated training bytes that read back as the pattern 100110011, followed by a sync byte. The sync-detect input closes the window. A mode input then decides what happens during user data. In one mode the coefficient freezes. In the other it keeps adapting with the gain divided by seven. A rate-select input scales the step size, so the integration time constant follows the data rate. A hold input freezes the coefficient whatever else happens. When the hold is released, normal behaviour resumes.

Top module: `eq_coef_ctrl`

## Requirements
- R1: Both coefficient outputs always carry the same value. A synchronous reset (`rst` high at a clock edge) loads `init_coef` into both outputs and closes no training window, so the next read starts in training.
- R2: Symbol encoding is 2'b01 = +1, 2'b11 = -1, and 2'b00 or 2'b10 = 0. The error is `sample_in - 32*cur`, where cur is the value of `sym_cur`. The internal accumulator has 16 bits: the coefficient followed by 6 guard bits. On a full-gain update it becomes `acc - (error * adj) * 2^rate_sel`, where adj is the value of `sym_adj`. The outputs show `acc >>> 6`, and they change at the same clock edge that captures the inputs.
- R3: `rate_sel` scales the update step by 2^rate_sel, with values from 0 to 3.
- R4: With `adapt_data` = 0, no update happens in a cycle where `sync_det` is high during a read. No update happens in any later cycle of the same read.
- R5: With `adapt_data` = 1, the step is the full-gain step divided by 7 and truncated toward zero. This applies in the cycle where sync is detected and in every later cycle of the same read.
- R6: While `hold` is high, the coefficient does not change, whatever the read, sync, mode, symbol or sample inputs are doing. After release, updates follow the normal rules. Leaving read mode during a hold still ends the training window.
- R7: While `read_mode` is low, the coefficient does not change. A read that starts after `read_mode` has dropped begins in training at full gain.
- R8: The accumulator saturates at +32767 and -32768, which are coefficient +511 and -512. It never wraps.
- R9: There is no update when `sample_vld` is low or when `sym_adj` decodes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_coef | input | 10 | Signed coefficient loaded at reset |
| sample_in | input | 8 | Signed equalizer output sample |
| sample_vld | input | 1 | Sample and symbols valid this cycle |
| sym_cur | input | 2 | Ternary symbol detected at this sample |
| sym_adj | input | 2 | Ternary symbol detected at the adjacent sample |
| read_mode | input | 1 | Read in progress |
| sync_det | input | 1 | Sync byte detected |
| hold | input | 1 | Freeze the coefficient |
| adapt_data | input | 1 | 1: keep adapting during user data at reduced gain |
| rate_sel | input | 2 | Data-rate step scale, step times 2^rate_sel |
| coef_pre | output | 10 | Signed coefficient for the inner tap before the centre |
| coef_post | output | 10 | Signed coefficient for the inner tap after the centre |

## Verification
The freeze properties assume that the only thing that can move the coefficient is an update enabled in the same cycle. They also assume `sync_det` matters only while `read_mode` is high. The bench therefore drives every input once per cycle, at the falling edge, and holds it steady across the rising edge. The no-wrap properties assume that one step moves the coefficient by less than half its range. The stimulus keeps samples within 8 bits and `rate_sel` within 0 to 3, which bounds one step to 20 coefficient counts.

// File: rtl/eq_coef_pkg.sv
package eq_coef_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRAIN = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    GAIN_OFF  = 2'd0,
    GAIN_FULL = 2'd1,
    GAIN_CUT  = 2'd2
  } gain_e;

  // ternary code: 01 = +1, 11 = -1, 00/10 = 0
  function automatic logic sym_nonzero(input logic [1:0] s);
    return s[0];
  endfunction

  function automatic logic sym_negative(input logic [1:0] s);
    return s[1] & s[0];
  endfunction

endpackage

// File: rtl/eq_zf_error.sv
module eq_zf_error #(
  parameter int SAMPLE_W = 8,
  parameter int AMP      = 32,
  parameter int RATE_W   = 2,
  parameter int DELTA_W  = 13
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [1:0]          sym_cur,
  input  logic        [1:0]          sym_adj,
  input  logic        [RATE_W-1:0]   rate_sel,
  output logic                       adj_nz,
  output logic signed [DELTA_W-1:0]  delta
);
  import eq_coef_pkg::*;

  localparam int ERR_W = SAMPLE_W + 2;
  localparam logic signed [ERR_W-1:0] AMP_S = ERR_W'(AMP);

  logic signed [ERR_W-1:0]   ideal;
  logic signed [ERR_W-1:0]   err;
  logic signed [DELTA_W-1:0] err_x;
  logic signed [DELTA_W-1:0] prod;

  always_comb begin
    if (!sym_nonzero(sym_cur))     ideal = '0;
    else if (sym_negative(sym_cur)) ideal = -AMP_S;
    else                            ideal = AMP_S;
    err   = {{2{sample[SAMPLE_W-1]}}, sample} - ideal;
    err_x = {{(DELTA_W-ERR_W){err[ERR_W-1]}}, err};
    prod  = sym_negative(sym_adj) ? -err_x : err_x;
    delta = prod <<< rate_sel;
    adj_nz = sym_nonzero(sym_adj);
  end

endmodule

// File: rtl/eq_phase_ctl.sv
module eq_phase_ctl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 read_mode,
  input  logic                 sync_det,
  input  logic                 hold,
  input  logic                 adapt_data,
  input  logic                 sample_vld,
  input  logic                 adj_nz,
  output eq_coef_pkg::gain_e   gain
);
  import eq_coef_pkg::*;

  phase_e phase_q;
  logic   trained;

  always_ff @(posedge clk) begin
    if (rst || !read_mode)                 phase_q <= PH_IDLE;
    else if (sync_det || phase_q == PH_DATA) phase_q <= PH_DATA;
    else                                   phase_q <= PH_TRAIN;
  end

  always_comb begin
    trained = (phase_q == PH_DATA) || sync_det;
    if (hold || !read_mode || !sample_vld || !adj_nz) gain = GAIN_OFF;
    else if (!trained)                                 gain = GAIN_FULL;
    else if (adapt_data)                               gain = GAIN_CUT;
    else                                               gain = GAIN_OFF;
  end

endmodule

// File: rtl/eq_coef_integ.sv
module eq_coef_integ #(
  parameter int COEF_W   = 10,
  parameter int GUARD_W  = 6,
  parameter int DELTA_W  = 13,
  parameter int GAIN_DIV = 7,
  parameter int NUM_TAPS = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic signed [COEF_W-1:0]         init_coef,
  input  eq_coef_pkg::gain_e               gain,
  input  logic signed [DELTA_W-1:0]        delta,
  output logic [NUM_TAPS-1:0][COEF_W-1:0]  taps
);
  import eq_coef_pkg::*;

  localparam int ACC_W = COEF_W + GUARD_W;
  localparam logic signed [DELTA_W-1:0] DIV_S = DELTA_W'(GAIN_DIV);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0]   acc_q;
  logic signed [ACC_W-1:0]   acc_next;
  logic signed [DELTA_W-1:0] step;
  logic signed [ACC_W:0]     sum;

  always_comb begin
    unique case (gain)
      GAIN_FULL: step = delta;
      GAIN_CUT:  step = delta / DIV_S;
      default:   step = '0;
    endcase
    sum = {acc_q[ACC_W-1], acc_q} - {{(ACC_W+1-DELTA_W){step[DELTA_W-1]}}, step};
    if (sum[ACC_W] != sum[ACC_W-1]) acc_next = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    else                            acc_next = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= {init_coef, {GUARD_W{1'b0}}};
    else     acc_q <= acc_next;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) taps[t] <= init_coef;
      else     taps[t] <= acc_next[ACC_W-1 -: COEF_W];
    end
  end

endmodule

// File: rtl/eq_coef_ctrl.sv
module eq_coef_ctrl #(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 10,
  parameter int GUARD_W  = 6,
  parameter int AMP      = 32,
  parameter int RATE_W   = 2,
  parameter int GAIN_DIV = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [COEF_W-1:0]  init_coef,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic                      sample_vld,
  input  logic [1:0]                sym_cur,
  input  logic [1:0]                sym_adj,
  input  logic                      read_mode,
  input  logic                      sync_det,
  input  logic                      hold,
  input  logic                      adapt_data,
  input  logic [RATE_W-1:0]         rate_sel,
  output logic signed [COEF_W-1:0]  coef_pre,
  output logic signed [COEF_W-1:0]  coef_post
);
  import eq_coef_pkg::*;

  localparam int NUM_TAPS = 2;
  localparam int DELTA_W  = SAMPLE_W + 2 + (2**RATE_W) - 1;

  logic                             adj_nz;
  logic signed [DELTA_W-1:0]        delta;
  gain_e                            gain;
  logic [NUM_TAPS-1:0][COEF_W-1:0]  taps;

  eq_zf_error #(
    .SAMPLE_W(SAMPLE_W), .AMP(AMP), .RATE_W(RATE_W), .DELTA_W(DELTA_W)
  ) u_err (
    .sample(sample_in), .sym_cur(sym_cur), .sym_adj(sym_adj),
    .rate_sel(rate_sel), .adj_nz(adj_nz), .delta(delta)
  );

  eq_phase_ctl u_phase (
    .clk(clk), .rst(rst), .read_mode(read_mode), .sync_det(sync_det),
    .hold(hold), .adapt_data(adapt_data), .sample_vld(sample_vld),
    .adj_nz(adj_nz), .gain(gain)
  );

  eq_coef_integ #(
    .COEF_W(COEF_W), .GUARD_W(GUARD_W), .DELTA_W(DELTA_W),
    .GAIN_DIV(GAIN_DIV), .NUM_TAPS(NUM_TAPS)
  ) u_integ (
    .clk(clk), .rst(rst), .init_coef(init_coef), .gain(gain),
    .delta(delta), .taps(taps)
  );

  assign coef_pre  = taps[0];
  assign coef_post = taps[1];

endmodule

// File: rtl/eq_coef_ctrl_chk.sv
module eq_coef_ctrl_chk #(
  parameter int COEF_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              read_mode,
  input logic              sync_det,
  input logic              hold,
  input logic              adapt_data,
  input logic              sample_vld,
  input logic [1:0]        sym_adj,
  input logic [COEF_W-1:0] coef_pre,
  input logic [COEF_W-1:0] coef_post
);
  localparam logic [COEF_W-1:0] C_MAX = {1'b0, {(COEF_W-1){1'b1}}};
  localparam logic [COEF_W-1:0] C_MIN = {1'b1, {(COEF_W-1){1'b0}}};

  a_r1_taps_match: assert property (@(posedge clk) disable iff (rst)
    coef_pre == coef_post);

  a_r6_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(coef_pre));

  a_r7_idle_freeze: assert property (@(posedge clk) disable iff (rst)
    !read_mode |=> $stable(coef_pre));

  a_r4_sync_stops: assert property (@(posedge clk) disable iff (rst)
    (read_mode && sync_det && !adapt_data) |=> $stable(coef_pre));

  a_r9_no_update: assert property (@(posedge clk) disable iff (rst)
    (!sample_vld || !sym_adj[0]) |=> $stable(coef_pre));

  a_r8_no_wrap_hi: assert property (@(posedge clk) disable iff (rst)
    (coef_pre == C_MAX) |=> !coef_pre[COEF_W-1]);

  a_r8_no_wrap_lo: assert property (@(posedge clk) disable iff (rst)
    (coef_pre == C_MIN) |=> coef_pre[COEF_W-1]);

endmodule

bind eq_coef_ctrl eq_coef_ctrl_chk #(.COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst(rst), .read_mode(read_mode), .sync_det(sync_det),
  .hold(hold), .adapt_data(adapt_data), .sample_vld(sample_vld),
  .sym_adj(sym_adj), .coef_pre(coef_pre), .coef_post(coef_post)
);

// File: tb/eq_coef_ctrl_test.sv
`timescale 1ns/1ps
module eq_coef_ctrl_test;

  typedef struct packed {
    logic       hold;
    logic       rd;
    logic       sy;
    logic       ad;
    logic       vl;
    logic [1:0] rate;
    logic [1:0] cur;
    logic [1:0] adj;
    logic [7:0] smp;
  } vec_t;

  // hold rd sy ad vl rate cur adj smp
  localparam vec_t VECS [16] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd2,2'b00,2'b01,8'h64}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,2'b11,2'b11,8'h9C}, // R3
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd0,2'b01,2'b11,8'h5A}, // R2
    '{1'b0,1'b1,1'b0,1'b0,1'b0,2'd3,2'b00,2'b01,8'h78}, // R9 vld low
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,2'b00,2'b00,8'h78}, // R9 adj 00
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,2'b00,2'b10,8'h78}, // R9 adj 10
    '{1'b1,1'b1,1'b0,1'b0,1'b1,2'd3,2'b00,2'b01,8'h88}, // R6 hold
    '{1'b1,1'b0,1'b0,1'b0,1'b1,2'd3,2'b00,2'b01,8'h88}, // R6 hold, read exit
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd1,2'b00,2'b01,8'hCE}, // R6 resume
    '{1'b0,1'b1,1'b1,1'b0,1'b1,2'd3,2'b00,2'b01,8'h7F}, // R4 sync cycle
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,2'b00,2'b01,8'h7F}, // R4 after sync
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,2'b00,2'b01,8'h7F}, // R7 read low
    '{1'b0,1'b1,1'b0,1'b1,1'b1,2'd3,2'b00,2'b01,8'h7F}, // R7 new read full gain
    '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd3,2'b00,2'b01,8'h7F}, // R5 sync cycle
    '{1'b0,1'b1,1'b0,1'b1,1'b1,2'd2,2'b11,2'b01,8'hF6}, // R5
    '{1'b0,1'b1,1'b0,1'b1,1'b1,2'd3,2'b00,2'b11,8'h7F}  // R5 negative
  };
  localparam int REQS [16] = '{2,3,2,9,9,9,6,6,6,4,4,7,7,5,5,5};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [9:0] init_coef = '0;
  logic signed [7:0] sample_in = '0;
  logic              sample_vld = 1'b0;
  logic [1:0]        sym_cur = '0;
  logic [1:0]        sym_adj = '0;
  logic              read_mode = 1'b0;
  logic              sync_det = 1'b0;
  logic              hold = 1'b0;
  logic              adapt_data = 1'b0;
  logic [1:0]        rate_sel = '0;
  logic signed [9:0] coef_pre;
  logic signed [9:0] coef_post;

  int n_chk = 0;
  int n_fail = 0;
  int acc_m = 0;
  bit seen_m = 1'b0;

  always #10 clk = ~clk;

  eq_coef_ctrl uut (
    .clk(clk), .rst(rst), .init_coef(init_coef), .sample_in(sample_in),
    .sample_vld(sample_vld), .sym_cur(sym_cur), .sym_adj(sym_adj),
    .read_mode(read_mode), .sync_det(sync_det), .hold(hold),
    .adapt_data(adapt_data), .rate_sel(rate_sel),
    .coef_pre(coef_pre), .coef_post(coef_post)
  );

  function automatic int sym_val(input logic [1:0] s);
    if (s == 2'b01) return 1;
    if (s == 2'b11) return -1;
    return 0;
  endfunction

  task automatic check(input int req);
    int e;
    e = acc_m >>> 6;
    n_chk++;
    if (coef_pre !== 10'(e) || coef_post !== 10'(e)) begin
      n_fail++;
      $display("FAIL R%0d: pre=%0d post=%0d expected=%0d", req, coef_pre, coef_post, e);
    end
  endtask

  task automatic model(input vec_t v);
    int full;
    bit trained;
    full = ($signed(v.smp) - 32 * sym_val(v.cur)) * sym_val(v.adj) * (1 << v.rate);
    trained = seen_m || v.sy;
    if (!v.hold && v.rd && v.vl && sym_val(v.adj) != 0) begin
      if (!trained)  acc_m = acc_m - full;
      else if (v.ad) acc_m = acc_m - (full / 7);
    end
    if (acc_m > 32767)  acc_m = 32767;
    if (acc_m < -32768) acc_m = -32768;
    if (!v.rd)     seen_m = 1'b0;
    else if (v.sy) seen_m = 1'b1;
  endtask

  task automatic drive(input vec_t v, input int req);
    @(negedge clk);
    rst = 1'b0;
    hold = v.hold; read_mode = v.rd; sync_det = v.sy; adapt_data = v.ad;
    sample_vld = v.vl; rate_sel = v.rate; sym_cur = v.cur; sym_adj = v.adj;
    sample_in = v.smp;
    model(v);
    @(posedge clk);
    #5;
    check(req);
  endtask

  task automatic do_reset(input logic signed [9:0] init);
    @(negedge clk);
    rst = 1'b1; init_coef = init;
    read_mode = 1'b0; sync_det = 1'b0; hold = 1'b0; sample_vld = 1'b0;
    acc_m = int'(init) * 64;
    seen_m = 1'b0;
    @(posedge clk);
    #5;
    check(1); // R1 reset value on both taps
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t sat_hi;
    vec_t sat_lo;
    do_reset(10'sd0);
    for (int i = 0; i < 16; i++) drive(VECS[i], REQS[i]);

    // R8 positive saturation
    sat_hi = '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,2'b00,2'b01,8'h80};
    do_reset(10'sd505);
    drive(sat_hi, 8);
    drive(sat_hi, 8);

    // R8 negative saturation
    sat_lo = '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd3,2'b00,2'b01,8'h7F};
    do_reset(-10'sd505);
    drive(sat_lo, 8);
    drive(sat_lo, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule